// File: doc/BRIEF.md
# PLL Reconfiguration Control Sequencer

This block is a hardware state machine that walks the control pins of a fractional-N PLL through power-up, power-down and divider changes, so that software issues one request and waits for one completion pulse. Requests arrive on a single-cycle request strobe with an operation code and a full set of divider values: multiplier m, predivider p, post-divider s and signed fractional k. The block holds the divider fields that the PLL sees. It drives the PLL's active-low reset, its bypass control and, on the integer-only variant, its lock-select control.

For a divider change, the block compares the new m and p with the ones the PLL is running on. If both match, it writes only the post-divider, and on the fractional variant the fractional value as well. This path leaves reset and bypass alone, so the output clock does not glitch. If m or p differs, it runs the full relock sequence. Time is measured on an external one-pulse-per-microsecond tick. The lock indication from the PLL is resynchronised by two flops before the state machine uses it.

A parameter selects the variant. With `FRAC_EN` = 1 the fractional value is honoured. With `FRAC_EN` = 0 the fractional field is held at zero, and the lock-select control is raised before the first reset assertion of a relock.

Top module: `pll_seq_ctrl`

## Requirements
- R1: After reset the PLL reset output is low, bypass and lock-select are low, busy, done and timeout are low, and the divider outputs hold their parameter defaults (`RST_M`, `RST_P`, `RST_S`, k = 0).
- R2: A divider request (op code 2) whose m and p equal the held ones updates only s, plus k when `FRAC_EN` = 1. The PLL reset output does not fall and bypass does not rise.
- R3: A divider request that changes m or p produces these steps on distinct, increasing cycles: reset driven low, then bypass high, then all divider fields loaded, then reset released, then bypass cleared. The divider fields m and p never change while reset is released.
- R4: Reset is released only after at least `SETTLE_US`+1 microsecond ticks have been seen following the divider load, and no more than one tick later. This guarantees a full `SETTLE_US` microseconds of settle time.
- R5: Bypass is cleared exactly four cycles after the PLL lock input rises: two synchroniser flops, one decision cycle and one update cycle.
- R6: If lock has not been seen after `LOCK_TIMEOUT_US` ticks counted from reset release, timeout pulses instead of done, and bypass stays high.
- R7: A prepare request (op code 0) with reset already released completes with done two cycles after acceptance and changes neither reset nor bypass. From the powered-down state it raises bypass, releases reset, waits for lock and then clears bypass.
- R8: An unprepare request (op code 1) drives the PLL reset output low and leaves bypass, lock-select and dividers unchanged.
- R9: Only one request runs at a time. Busy is high from the cycle after acceptance until completion. A request strobed while busy, or with op code 3, is ignored and produces no busy and no done.
- R10: With `FRAC_EN` = 0, lock-select rises on an earlier cycle than the first reset fall of a relock and then stays high, and the k output stays zero.
- R11: Done and timeout are single-cycle pulses, are never high together, and are high only while busy is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, one cycle |
| req_op | input | 2 | 0 prepare, 1 unprepare, 2 set dividers, 3 no operation |
| req_m | input | M_W | Requested multiplier |
| req_p | input | P_W | Requested predivider |
| req_s | input | S_W | Requested post-divider |
| req_k | input | K_W | Requested signed fractional value |
| pll_lock | input | 1 | Asynchronous lock indication from the PLL |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| pll_rst_n | output | 1 | Active-low PLL reset |
| pll_bypass | output | 1 | PLL bypass control |
| pll_lock_sel | output | 1 | Lock-source select, integer variant only |
| div_m | output | M_W | Multiplier applied to the PLL |
| div_p | output | P_W | Predivider applied to the PLL |
| div_s | output | S_W | Post-divider applied to the PLL |
| div_k | output | K_W | Fractional value applied to the PLL |
| busy | output | 1 | Request in progress |
| done | output | 1 | Completion pulse |
| timeout | output | 1 | Lock-wait expiry pulse |

## Verification
The bench drives a fractional and an integer instance side by side, each with its own delayed-lock model. It records the cycle and tick stamp of every control edge.

- **Step order.** A design that merged two steps of the relock order, or let m or p move while reset was released, fails the ordering checks.
- **Settle window.** A settle counter that is one tick short releases reset one microsecond early and is caught by the tick-count window.
- **Lock timeout.** An off-by-one lock-wait limit is caught by the exact 10000-tick count to timeout.
- **Synchroniser depth.** A synchroniser with a missing flop clears bypass a cycle early.
- **Glitch-free path.** The bench repeats m and p, then checks that neither reset nor bypass moved.
- **Ignored requests.** A request strobed while busy, and one with op code 3, must leave the dividers and completion pulses untouched.
- **Unprepare after timeout.** The bench issues an unprepare after a timeout and checks that bypass is left high.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

  typedef enum logic [1:0] {
    OP_PREP   = 2'd0,
    OP_UNPREP = 2'd1,
    OP_SETDIV = 2'd2,
    OP_NONE   = 2'd3
  } op_e;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_LSEL,
    ST_RSTA,
    ST_BYP,
    ST_LOAD,
    ST_SETTLE,
    ST_REL,
    ST_LOCK,
    ST_BCLR,
    ST_FIN
  } st_e;

endpackage

// File: rtl/pll_lock_sync.sv
module pll_lock_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[0] <= 1'b0;
          else        chain_q[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain_q[i] <= 1'b0;
          else        chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain_q[STAGES-1];

endmodule

// File: rtl/pll_us_timer.sv
module pll_us_timer #(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  output logic [CNT_W-1:0] count
);

  localparam logic [CNT_W-1:0] SAT = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = clr || (tick && cnt_q != SAT);
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;

endmodule

// File: rtl/pll_seq_ctrl.sv
module pll_seq_ctrl
  import pll_seq_pkg::*;
#(
  parameter int M_W             = 10,
  parameter int P_W             = 6,
  parameter int S_W             = 3,
  parameter int K_W             = 16,
  parameter int SETTLE_US       = 3,
  parameter int LOCK_TIMEOUT_US = 10000,
  parameter int SYNC_STAGES     = 2,
  parameter int FRAC_EN         = 1,
  parameter int RST_M           = 250,
  parameter int RST_P           = 3,
  parameter int RST_S           = 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic [1:0]     req_op,
  input  logic [M_W-1:0] req_m,
  input  logic [P_W-1:0] req_p,
  input  logic [S_W-1:0] req_s,
  input  logic [K_W-1:0] req_k,
  input  logic           pll_lock,
  input  logic           us_tick,
  output logic           pll_rst_n,
  output logic           pll_bypass,
  output logic           pll_lock_sel,
  output logic [M_W-1:0] div_m,
  output logic [P_W-1:0] div_p,
  output logic [S_W-1:0] div_s,
  output logic [K_W-1:0] div_k,
  output logic           busy,
  output logic           done,
  output logic           timeout
);

  localparam int CNT_MAX = (SETTLE_US + 1 > LOCK_TIMEOUT_US) ? SETTLE_US + 1 : LOCK_TIMEOUT_US;
  localparam int CNT_W   = $clog2(CNT_MAX + 2);
  localparam logic [CNT_W-1:0] SETTLE_END = CNT_W'(SETTLE_US);
  localparam logic [CNT_W-1:0] WAIT_END   = CNT_W'(LOCK_TIMEOUT_US - 1);

  st_e              state_q, state_d;
  op_e              op_q;
  logic [M_W-1:0]   pm_q, m_q;
  logic [P_W-1:0]   pp_q, p_q;
  logic [S_W-1:0]   ps_q, s_q;
  logic             prst_q, byp_q, lsel_q, done_q, to_q;
  logic             lock_s;
  logic [CNT_W-1:0] tcnt;

  logic acc, mp_same, settle_hit, wait_hit;
  logic tmr_clr, load_full, apply_fast;
  logic rst_lo, rst_hi, byp_hi, byp_lo, lsel_hi, done_d, to_d;

  pll_lock_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (pll_lock),
    .sync_out (lock_s)
  );

  pll_us_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (tmr_clr),
    .tick  (us_tick),
    .count (tcnt)
  );

  // Next-state logic
  always_comb begin
    acc        = (state_q == ST_IDLE) && req_valid && (op_e'(req_op) != OP_NONE);
    mp_same    = (req_m == m_q) && (req_p == p_q);
    settle_hit = us_tick && (tcnt == SETTLE_END);
    wait_hit   = us_tick && (tcnt == WAIT_END);
    state_d    = state_q;
    unique case (state_q)
      ST_IDLE: begin
        if (acc) begin
          unique case (op_e'(req_op))
            OP_PREP:   state_d = prst_q ? ST_FIN : ST_BYP;
            OP_UNPREP: state_d = ST_FIN;
            default:   state_d = mp_same ? ST_FIN : ((FRAC_EN != 0) ? ST_RSTA : ST_LSEL);
          endcase
        end
      end
      ST_LSEL:   state_d = ST_RSTA;
      ST_RSTA:   state_d = ST_BYP;
      ST_BYP:    state_d = (op_q == OP_SETDIV) ? ST_LOAD : ST_REL;
      ST_LOAD:   state_d = ST_SETTLE;
      ST_SETTLE: if (settle_hit) state_d = ST_REL;
      ST_REL:    state_d = ST_LOCK;
      ST_LOCK: begin
        if (lock_s)        state_d = ST_BCLR;
        else if (wait_hit) state_d = ST_IDLE;
      end
      ST_BCLR:   state_d = ST_IDLE;
      ST_FIN:    state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // Per-state actions as register enables
  always_comb begin
    tmr_clr    = (state_q == ST_LOAD) || (state_q == ST_REL);
    load_full  = (state_q == ST_LOAD);
    apply_fast = (state_q == ST_FIN) && (op_q == OP_SETDIV);
    rst_lo     = (state_q == ST_RSTA) || ((state_q == ST_FIN) && (op_q == OP_UNPREP));
    rst_hi     = (state_q == ST_REL);
    byp_hi     = (state_q == ST_BYP);
    byp_lo     = (state_q == ST_BCLR);
    lsel_hi    = (state_q == ST_LSEL);
    done_d     = (state_q == ST_BCLR) || (state_q == ST_FIN);
    to_d       = (state_q == ST_LOCK) && !lock_s && wait_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      to_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      to_q    <= to_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q <= OP_NONE;
      pm_q <= '0;
      pp_q <= '0;
      ps_q <= '0;
    end else if (acc) begin
      op_q <= op_e'(req_op);
      pm_q <= req_m;
      pp_q <= req_p;
      ps_q <= req_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prst_q <= 1'b0;
    end else if (rst_lo || rst_hi) begin
      prst_q <= rst_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byp_q <= 1'b0;
    end else if (byp_hi || byp_lo) begin
      byp_q <= byp_hi;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lsel_q <= 1'b0;
    else if (lsel_hi) lsel_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_q <= M_W'(RST_M);
      p_q <= P_W'(RST_P);
    end else if (load_full) begin
      m_q <= pm_q;
      p_q <= pp_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       s_q <= S_W'(RST_S);
    else if (load_full || apply_fast) s_q <= ps_q;
  end

  generate
    if (FRAC_EN != 0) begin : g_frac
      logic [K_W-1:0] pk_q, k_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   pk_q <= '0;
        else if (acc) pk_q <= req_k;
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       k_q <= '0;
        else if (load_full || apply_fast) k_q <= pk_q;
      end
      assign div_k = k_q;
    end else begin : g_int
      assign div_k = '0;
    end
  endgenerate

  assign pll_rst_n    = prst_q;
  assign pll_bypass   = byp_q;
  assign pll_lock_sel = lsel_q;
  assign div_m        = m_q;
  assign div_p        = p_q;
  assign div_s        = s_q;
  assign busy         = (state_q != ST_IDLE);
  assign done         = done_q;
  assign timeout      = to_q;

endmodule

// File: rtl/pll_seq_chk.sv
module pll_seq_chk #(
  parameter int M_W     = 10,
  parameter int P_W     = 6,
  parameter int FRAC_EN = 1
) (
  input logic           clk,
  input logic           rst_n,
  input logic           req_valid,
  input logic           pll_rst_n,
  input logic           pll_bypass,
  input logic           pll_lock_sel,
  input logic [M_W-1:0] div_m,
  input logic [P_W-1:0] div_p,
  input logic           busy,
  input logic           done,
  input logic           timeout
);

  assert_end_excl_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, timeout}));

  assert_end_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (done || timeout) |-> !busy);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R3 and R7: reset is only ever released with bypass already high
  assert_release_bypassed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pll_rst_n) |-> pll_bypass);

  assert_mp_in_reset_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(div_m) || !$stable(div_p)) |-> (!pll_rst_n && pll_bypass));

  assert_bypass_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pll_bypass) |-> pll_rst_n);

  assert_timeout_bypass_R6: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |-> pll_bypass);

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  generate
    if (FRAC_EN == 0) begin : g_int_chk
      assert_lsel_first_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(div_m) |-> pll_lock_sel);
    end
  endgenerate

endmodule

bind pll_seq_ctrl pll_seq_chk #(.M_W(M_W), .P_W(P_W), .FRAC_EN(FRAC_EN)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .pll_rst_n    (pll_rst_n),
  .pll_bypass   (pll_bypass),
  .pll_lock_sel (pll_lock_sel),
  .div_m        (div_m),
  .div_p        (div_p),
  .busy         (busy),
  .done         (done),
  .timeout      (timeout)
);

// File: tb/pll_seq_ctrl_tb.sv
module pll_seq_ctrl_tb;

  localparam int TO_US = 10000;
  localparam int ST_US = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [1:0] req_op = 2'd3;
  logic [9:0] req_m = '0;
  logic [5:0] req_p = '0;
  logic [2:0] req_s = '0;
  logic [15:0] req_k = '0;
  logic us_tick = 1'b0;
  logic [1:0] lock_i = '0;
  logic [1:0] rst_o, byp_o, lsel_o, busy_o, done_o, to_o;
  logic [9:0] m_o [2];
  logic [5:0] p_o [2];
  logic [2:0] s_o [2];
  logic [15:0] k_o [2];

  int total = 0, fails = 0;
  int cyc = 0, ticks = 0, tdiv = 0;
  int lock_dly = 20;
  int lcnt [2];
  logic [1:0] prst = '0, pbyp = '0, plsel = '0, plock = '0;
  logic [9:0] pm [2];
  int t_rfall [2], t_rrise [2], t_brise [2], t_bfall [2], t_load [2], t_lock [2], t_lsel [2];
  int k_load [2], k_rrise [2], k_to [2], n_done [2], n_to [2];
  bit saw_busy [2], end_f [2];
  int bad_lsel = 0;

  always #5 clk = ~clk;

  for (genvar d = 0; d < 2; d++) begin : g_dut
    pll_seq_ctrl #(.FRAC_EN(d == 0 ? 1 : 0), .SETTLE_US(ST_US), .LOCK_TIMEOUT_US(TO_US)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
      .req_m(req_m), .req_p(req_p), .req_s(req_s), .req_k(req_k),
      .pll_lock(lock_i[d]), .us_tick(us_tick),
      .pll_rst_n(rst_o[d]), .pll_bypass(byp_o[d]), .pll_lock_sel(lsel_o[d]),
      .div_m(m_o[d]), .div_p(p_o[d]), .div_s(s_o[d]), .div_k(k_o[d]),
      .busy(busy_o[d]), .done(done_o[d]), .timeout(to_o[d]));
  end

  always @(negedge clk) begin
    tdiv = (tdiv == 3) ? 0 : tdiv + 1;
    us_tick = (tdiv == 0);
  end

  // Monitor plus delayed-lock PLL model, sampled just after each edge
  always @(posedge clk) begin
    #1;
    cyc++;
    if (us_tick) ticks++;
    for (int d = 0; d < 2; d++) begin
      if (!rst_o[d]) lcnt[d] = 0;
      else if (lcnt[d] < 1000000) lcnt[d]++;
      lock_i[d] = rst_o[d] && (lcnt[d] >= lock_dly);
      if (lock_i[d] && !plock[d]) t_lock[d] = cyc;
      if (prst[d] && !rst_o[d]) begin
        t_rfall[d] = cyc;
        if (d == 1 && busy_o[1] && !lsel_o[1]) bad_lsel++;
      end
      if (!prst[d] && rst_o[d]) begin t_rrise[d] = cyc; k_rrise[d] = ticks; end
      if (!pbyp[d] && byp_o[d]) t_brise[d] = cyc;
      if (pbyp[d] && !byp_o[d]) t_bfall[d] = cyc;
      if (!plsel[d] && lsel_o[d]) t_lsel[d] = cyc;
      if (pm[d] != m_o[d]) begin t_load[d] = cyc; k_load[d] = ticks; end
      if (busy_o[d]) saw_busy[d] = 1'b1;
      if (done_o[d]) begin n_done[d]++; end_f[d] = 1'b1; end
      if (to_o[d]) begin n_to[d]++; end_f[d] = 1'b1; k_to[d] = ticks; end
      prst[d] = rst_o[d]; pbyp[d] = byp_o[d]; plsel[d] = lsel_o[d];
      plock[d] = lock_i[d]; pm[d] = m_o[d];
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_true(input string tag, input bit ok, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic arm();
    for (int d = 0; d < 2; d++) begin
      t_rfall[d] = -1; t_rrise[d] = -1; t_brise[d] = -1; t_bfall[d] = -1;
      t_load[d] = -1; t_lock[d] = -1; k_load[d] = 0; k_rrise[d] = 0; k_to[d] = 0;
      n_done[d] = 0; n_to[d] = 0; saw_busy[d] = 1'b0; end_f[d] = 1'b0;
    end
  endtask

  task automatic send(input logic [1:0] op, input int m, input int p, input int s, input int k);
    @(negedge clk);
    arm();
    req_valid = 1'b1; req_op = op;
    req_m = 10'(m); req_p = 6'(p); req_s = 3'(s); req_k = 16'(k);
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
  endtask

  task automatic wait_end();
    for (int i = 0; i < 60000; i++) begin
      @(negedge clk);
      if (end_f[0] && end_f[1]) break;
    end
    @(negedge clk);
  endtask

  // Full relock checks for one instance
  task automatic chk_full(input int d, input int m, input int p, input int s, input int k);
    chk_true("R3 reset falls", t_rfall[d] >= 0, t_rfall[d], 0);
    chk_true("R3 bypass after reset", t_brise[d] > t_rfall[d], t_brise[d], t_rfall[d] + 1);
    chk_true("R3 load after bypass", t_load[d] > t_brise[d], t_load[d], t_brise[d] + 1);
    chk_true("R3 release after load", t_rrise[d] > t_load[d], t_rrise[d], t_load[d] + 1);
    chk_true("R4 settle ticks", (k_rrise[d] - k_load[d] >= ST_US + 1) && (k_rrise[d] - k_load[d] <= ST_US + 2),
             k_rrise[d] - k_load[d], ST_US + 1);
    chk("R5 bypass clear after lock", t_bfall[d], t_lock[d] + 4);
    chk("R3 m loaded", m_o[d], m);
    chk("R3 p loaded", p_o[d], p);
    chk("R3 s loaded", s_o[d], s);
    chk("R3 k loaded", longint'($signed(k_o[d])), (d == 0) ? k : 0);
    chk("R11 one done", n_done[d], 1);
    chk("R11 no timeout", n_to[d], 0);
    chk("R3 final reset/bypass", {rst_o[d], byp_o[d]}, 2'b10);
  endtask

  initial begin
    arm();
    for (int d = 0; d < 2; d++) begin t_lsel[d] = -1; lcnt[d] = 0; pm[d] = 10'd250; end
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int d = 0; d < 2; d++) begin
      chk("R1 pll reset low", rst_o[d], 0);
      chk("R1 bypass/lsel low", {byp_o[d], lsel_o[d]}, 0);
      chk("R1 busy/done/timeout low", {busy_o[d], done_o[d], to_o[d]}, 0);
      chk("R1 default m", m_o[d], 250);
      chk("R1 default p/s/k", {p_o[d], s_o[d], k_o[d]}, {6'd3, 3'd1, 16'd0});
    end

    // R9 op code 3 ignored
    send(2'd3, 400, 9, 5, 9);
    repeat (6) @(negedge clk);
    for (int d = 0; d < 2; d++) begin
      chk("R9 op3 no busy", saw_busy[d], 0);
      chk("R9 op3 no done", n_done[d], 0);
      chk("R9 op3 m unchanged", m_o[d], 250);
    end

    // R7 prepare from powered-down
    send(2'd0, 0, 0, 0, 0);
    wait_end();
    for (int d = 0; d < 2; d++) begin
      chk_true("R7 bypass before release", t_brise[d] >= 0 && t_brise[d] < t_rrise[d], t_brise[d], t_rrise[d] - 1);
      chk("R7 bypass cleared after lock (R5)", t_bfall[d], t_lock[d] + 4);
      chk("R7 final reset/bypass", {rst_o[d], byp_o[d]}, 2'b10);
      chk("R7 done", n_done[d], 1);
      chk("R9 busy seen", saw_busy[d], 1);
    end

    // R7 prepare when already running
    send(2'd0, 0, 0, 0, 0);
    @(negedge clk);
    for (int d = 0; d < 2; d++) chk("R7 quick done", done_o[d], 1);
    wait_end();
    for (int d = 0; d < 2; d++) begin
      chk("R7 no bypass rise", t_brise[d], -1);
      chk("R7 no reset fall", t_rfall[d], -1);
    end

    // R2 glitch-free change
    send(2'd2, 250, 3, 4, -5);
    wait_end();
    for (int d = 0; d < 2; d++) begin
      chk("R2 no reset fall", t_rfall[d], -1);
      chk("R2 no bypass rise", t_brise[d], -1);
      chk("R2 s updated", s_o[d], 4);
      chk("R2 k updated", longint'($signed(k_o[d])), (d == 0) ? -5 : 0);
      chk("R2 done", n_done[d], 1);
    end

    // R3 sweep of full relocks
    for (int i = 0; i < 4; i++) begin
      int m, p, s, k;
      case (i)
        0: begin m = 320;  p = 4;  s = 2; k = 1234;   end
        1: begin m = 150;  p = 2;  s = 1; k = -700;   end
        2: begin m = 1023; p = 63; s = 6; k = 32767;  end
        default: begin m = 64; p = 1; s = 0; k = -32768; end
      endcase
      send(2'd2, m, p, s, k);
      wait_end();
      for (int d = 0; d < 2; d++) chk_full(d, m, p, s, k);
      if (i == 0) chk_true("R10 lock-select before reset fall", t_lsel[1] >= 0 && t_lsel[1] < t_rfall[1], t_lsel[1], t_rfall[1] - 1);
    end
    chk("R10 no reset fall without lock-select", bad_lsel, 0);
    chk("R10 lock-select held", lsel_o[1], 1);
    chk("R10 frac variant lock-select low", lsel_o[0], 0);

    // R6 lock timeout
    lock_dly = 32'h7fffffff;
    send(2'd2, 500, 5, 3, 77);
    wait_end();
    for (int d = 0; d < 2; d++) begin
      chk("R6 timeout pulse", n_to[d], 1);
      chk("R6 no done", n_done[d], 0);
      chk("R6 ticks to timeout", k_to[d] - k_rrise[d], TO_US);
      chk("R6 bypass held", byp_o[d], 1);
    end
    lock_dly = 20;

    // R8 unprepare only drops reset
    send(2'd1, 7, 7, 7, 7);
    wait_end();
    for (int d = 0; d < 2; d++) begin
      chk("R8 reset low", rst_o[d], 0);
      chk("R8 bypass untouched", byp_o[d], 1);
      chk("R8 dividers untouched", {m_o[d], p_o[d], s_o[d]}, {10'd500, 6'd5, 3'd3});
      chk("R8 done", n_done[d], 1);
    end

    // R7 prepare recovers from bypassed power-down
    send(2'd0, 0, 0, 0, 0);
    wait_end();
    for (int d = 0; d < 2; d++) chk("R7 recovered", {rst_o[d], byp_o[d]}, 2'b10);

    // R9 request while busy ignored
    send(2'd2, 600, 6, 2, 11);
    repeat (2) @(negedge clk);
    req_valid = 1'b1; req_op = 2'd2; req_m = 10'd700; req_p = 6'd7;
    @(negedge clk);
    req_valid = 1'b0; req_op = 2'd3;
    wait_end();
    for (int d = 0; d < 2; d++) begin
      chk("R9 busy request ignored m", m_o[d], 600);
      chk("R9 busy request ignored p", p_o[d], 6);
      chk("R9 single done", n_done[d], 1);
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", cyc, 200000);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule